// File: doc/BRIEF.md
# Miss-Ranked Victim Selector With Line Pinning

This block holds the replacement state for one set of a set-associative cache and chooses the way to evict on each fill. Each way carries a valid flag, a pin flag, a recorded miss count and an age. The miss count is supplied by the requester with every fill, taken from an external table of how often each block is expected to miss. The block never evicts a pinned way. Among the unpinned ways it prefers an empty one. Failing that, it takes the way with the fewest recorded misses, and uses age only to break a tie.

A mode input, `lru_only`, ignores the miss counts so that the same logic serves as a plain least-recently-used policy for a first-level cache. Pin and unpin commands mark ways to keep. At most a quarter of the ways may be pinned, so an unpinned candidate always exists. A hit to a pinned way updates the age order like any other hit. Ages start at the way index after reset, with way 0 the youngest.

A small controller with three states sequences the outputs. `SEL_IDLE` is the state with nothing to report. A fill request moves it to `SEL_REPORT` for one cycle, and in that cycle `victim_valid` is high. A rejected pin request moves it to `SEL_REJECT` for one cycle, and in that cycle `pin_reject` is high. Every other cycle returns it to `SEL_IDLE`. A new request is accepted in every state, so these transitions apply from each of the three states.

Top module: `missrank_victim_sel`

## Requirements
- R1: A pinned way is never reported as the victim.
- R2: If any unpinned way is invalid, the victim is the lowest-numbered such way.
- R3: When all unpinned ways are valid and `lru_only` is 0, the victim is the unpinned way with the smallest recorded miss count.
- R4: When several unpinned valid ways share the smallest count, the oldest of them (largest age) is chosen.
- R5: With `lru_only` = 1, miss counts are ignored and the victim is the oldest unpinned way, after any invalid way.
- R6: The pin limit is WAYS×25/100, which is 2 for 8 ways. A pin request for an unpinned way while that many ways are already pinned changes nothing and raises `pin_reject` for one cycle, starting one cycle after the request. Re-pinning a way that is already pinned is accepted silently.
- R7: An unpin request clears the pin flag of the addressed way, which frees a slot under the limit.
- R8: On a hit (`touch_en`), including a hit to a pinned way, the touched way becomes age 0 and every way younger than it ages by one.
- R9: `victim_valid` is high for exactly the one cycle after a fill request, with `victim_way` valid in that same cycle.
- R10: On a fill, the victim way becomes valid, stores `fill_misses` as its count and becomes the youngest way.
- R11: After reset, all ways are invalid and unpinned, ages equal the way index, and both output pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| touch_en | input | 1 | Hit on `touch_way`; updates ages |
| touch_way | input | 3 | Way that was hit |
| fill_req | input | 1 | Request a victim and install a new line in it |
| fill_misses | input | 8 | Miss count stored with the filled line |
| pin_req | input | 1 | Pin `pin_way` |
| unpin_req | input | 1 | Unpin `pin_way` |
| pin_way | input | 3 | Way addressed by pin or unpin |
| lru_only | input | 1 | 1: ignore miss counts when choosing |
| victim_valid | output | 1 | One-cycle pulse marking `victim_way` |
| victim_way | output | 3 | Chosen victim way |
| pin_reject | output | 1 | One-cycle pulse: pin refused at the limit |

## Verification
The assertions take for granted that the requester issues at most one command per cycle. If commands do collide, fill wins over pin, pin wins over unpin, and unpin wins over a hit. They also assume that `touch_way` names a line the requester knows to be present. The stimulus drives a single command per cycle and touches only filled ways. It first walks a fill sequence that empties the invalid pool, then exercises ties, pinning at and past the limit, and both selection modes with hand-computed ages and counts.

// File: rtl/missrank_pkg.sv
package missrank_pkg;
    typedef enum logic [1:0] {
        SEL_IDLE   = 2'd0,
        SEL_REPORT = 2'd1,
        SEL_REJECT = 2'd2
    } sel_state_e;
endpackage

// File: rtl/missrank_age.sv
module missrank_age #(
    parameter int WAYS = 8,
    parameter int AW   = $clog2(WAYS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    touch,
    input  logic [AW-1:0]           touch_way,
    output logic [WAYS-1:0][AW-1:0] ages
);
    logic [AW-1:0] hit_age;

    assign hit_age = ages[touch_way];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) ages[w] <= AW'(w);
        end else if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
                if (AW'(w) == touch_way)   ages[w] <= '0;
                else if (ages[w] < hit_age) ages[w] <= ages[w] + 1'b1;
            end
        end
    end

    // Ages must always form a permutation of 0..WAYS-1.
    logic [WAYS-1:0] age_seen;
    always_comb begin
        age_seen = '0;
        for (int w = 0; w < WAYS; w++) age_seen[ages[w]] = 1'b1;
    end

    assert_ages_distinct_R8: assert property (@(posedge clk) disable iff (!rst_n)
        &age_seen);

    assert_touch_youngest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> ages[$past(touch_way)] == '0);
endmodule

// File: rtl/missrank_pin.sv
module missrank_pin #(
    parameter int WAYS    = 8,
    parameter int PIN_MAX = 2,
    parameter int AW      = $clog2(WAYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin,
    input  logic            unpin,
    input  logic [AW-1:0]   way,
    output logic [WAYS-1:0] pinned,
    output logic            refuse
);
    localparam int CW = $clog2(WAYS + 1);

    logic [CW-1:0] pin_cnt;

    always_comb begin
        pin_cnt = '0;
        for (int w = 0; w < WAYS; w++) pin_cnt = pin_cnt + CW'(pinned[w]);
    end

    assign refuse = pin && !pinned[way] && (pin_cnt >= CW'(PIN_MAX));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pinned <= '0;
        end else if (pin && !refuse) begin
            pinned[way] <= 1'b1;
        end else if (unpin) begin
            pinned[way] <= 1'b0;
        end
    end

    assert_pin_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pinned) <= PIN_MAX);

    assert_unpin_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (unpin && !pin) |=> !pinned[$past(way)]);
endmodule

// File: rtl/missrank_pick.sv
module missrank_pick #(
    parameter int WAYS = 8,
    parameter int CNTW = 8,
    parameter int AW   = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]           valid,
    input  logic [WAYS-1:0]           pinned,
    input  logic [WAYS-1:0][CNTW-1:0] counts,
    input  logic [WAYS-1:0][AW-1:0]   ages,
    input  logic                      lru_only,
    output logic [AW-1:0]             pick,
    output logic                      found
);
    localparam int KW = CNTW + AW;

    logic [WAYS-1:0] free_slot;
    logic [AW-1:0]   free_way;
    logic            free_any;
    logic [WAYS-1:0][KW-1:0] rank;
    logic [AW-1:0]   best_way;
    logic [KW-1:0]   best_key;
    logic            best_any;

    // Rank key: smaller is better. Count first (zeroed in LRU mode), then
    // inverted age so the oldest way has the smallest tail.
    genvar g;
    generate
        for (g = 0; g < WAYS; g++) begin : g_rank
            assign free_slot[g] = !valid[g] && !pinned[g];
            assign rank[g] = {(lru_only ? {CNTW{1'b0}} : counts[g]),
                              AW'(WAYS - 1) - ages[g]};
        end
    endgenerate

    always_comb begin
        free_way = '0;
        free_any = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (free_slot[w]) begin
                free_way = AW'(w);
                free_any = 1'b1;
            end
        end
    end

    always_comb begin
        best_way = '0;
        best_key = '1;
        best_any = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!pinned[w] && (!best_any || rank[w] < best_key)) begin
                best_way = AW'(w);
                best_key = rank[w];
                best_any = 1'b1;
            end
        end
    end

    assign pick  = free_any ? free_way : best_way;
    assign found = free_any || best_any;
endmodule

// File: rtl/missrank_victim_sel.sv
module missrank_victim_sel #(
    parameter int WAYS    = 8,
    parameter int CNTW    = 8,
    parameter int PIN_PCT = 25,
    parameter int AW      = $clog2(WAYS),
    parameter int PIN_MAX = WAYS * PIN_PCT / 100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            touch_en,
    input  logic [AW-1:0]   touch_way,
    input  logic            fill_req,
    input  logic [CNTW-1:0] fill_misses,
    input  logic            pin_req,
    input  logic            unpin_req,
    input  logic [AW-1:0]   pin_way,
    input  logic            lru_only,
    output logic            victim_valid,
    output logic [AW-1:0]   victim_way,
    output logic            pin_reject
);
    import missrank_pkg::*;

    sel_state_e state_q, state_d;

    logic [WAYS-1:0]           line_valid;
    logic [WAYS-1:0][CNTW-1:0] line_cnt;
    logic [WAYS-1:0]           pinned;
    logic [WAYS-1:0][AW-1:0]   ages;
    logic [AW-1:0]             pick;
    logic                      found;
    logic                      refuse;
    logic                      do_fill, do_pin, do_unpin, do_touch;
    logic                      age_touch;
    logic [AW-1:0]             age_way;

    // One command per cycle; collisions resolve fill > pin > unpin > hit.
    assign do_fill  = fill_req;
    assign do_pin   = pin_req && !fill_req;
    assign do_unpin = unpin_req && !fill_req && !pin_req;
    assign do_touch = touch_en && !fill_req && !pin_req && !unpin_req;

    assign age_touch = do_fill || do_touch;
    assign age_way   = do_fill ? pick : touch_way;

    missrank_age #(.WAYS(WAYS), .AW(AW)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (age_touch),
        .touch_way (age_way),
        .ages      (ages)
    );

    missrank_pin #(.WAYS(WAYS), .PIN_MAX(PIN_MAX), .AW(AW)) u_pin (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (do_pin),
        .unpin  (do_unpin),
        .way    (pin_way),
        .pinned (pinned),
        .refuse (refuse)
    );

    missrank_pick #(.WAYS(WAYS), .CNTW(CNTW), .AW(AW)) u_pick (
        .valid    (line_valid),
        .pinned   (pinned),
        .counts   (line_cnt),
        .ages     (ages),
        .lru_only (lru_only),
        .pick     (pick),
        .found    (found)
    );

    // Per-line contents written on fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_valid <= '0;
            line_cnt   <= '0;
        end else if (do_fill) begin
            line_valid[pick] <= 1'b1;
            line_cnt[pick]   <= fill_misses;
        end
    end

    // Victim index register.
    always_ff @(posedge clk) begin
        if (!rst_n)       victim_way <= '0;
        else if (do_fill) victim_way <= pick;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEL_IDLE;
        else        state_q <= state_d;
    end

    // Next state: every state accepts a new command.
    always_comb begin
        unique case (state_q)
            SEL_IDLE, SEL_REPORT, SEL_REJECT: begin
                if (do_fill)                state_d = SEL_REPORT;
                else if (do_pin && refuse)  state_d = SEL_REJECT;
                else                        state_d = SEL_IDLE;
            end
            default: state_d = SEL_IDLE;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        victim_valid = 1'b0;
        pin_reject   = 1'b0;
        unique case (state_q)
            SEL_IDLE:   ;
            SEL_REPORT: victim_valid = 1'b1;
            SEL_REJECT: pin_reject   = 1'b1;
            default:    ;
        endcase
    end

    assert_victim_unpinned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> !pinned[victim_way]);

    assert_victim_filled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> line_valid[victim_way]);

    assert_victim_after_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> $past(fill_req));

    assert_reject_after_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pin_reject |-> ($past(pin_req) && !$past(fill_req)));

    assert_candidate_exists_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> found);

    assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(victim_valid && pin_reject));
endmodule

// File: tb/missrank_victim_sel_bench.sv
module missrank_victim_sel_bench;
    localparam int OP_TOUCH = 0, OP_FILL = 1, OP_PIN = 2, OP_UNPIN = 3;
    localparam int NV = 24;

    // Row: {req[3:0], op[1:0], way[2:0], cnt[7:0], lru, exp_way[2:0], exp_rej}
    localparam logic [21:0] VEC [NV] = '{
        {4'd2,  2'd1, 3'd0, 8'd5, 1'b0, 3'd0, 1'b0}, // R2 empty set, way 0
        {4'd2,  2'd1, 3'd0, 8'd3, 1'b0, 3'd1, 1'b0}, // R2
        {4'd2,  2'd1, 3'd0, 8'd7, 1'b0, 3'd2, 1'b0}, // R2
        {4'd2,  2'd1, 3'd0, 8'd3, 1'b0, 3'd3, 1'b0}, // R2
        {4'd2,  2'd1, 3'd0, 8'd9, 1'b0, 3'd4, 1'b0}, // R2
        {4'd2,  2'd1, 3'd0, 8'd2, 1'b0, 3'd5, 1'b0}, // R2
        {4'd2,  2'd1, 3'd0, 8'd6, 1'b0, 3'd6, 1'b0}, // R2
        {4'd2,  2'd1, 3'd0, 8'd4, 1'b0, 3'd7, 1'b0}, // R2 last empty way
        {4'd3,  2'd1, 3'd0, 8'd8, 1'b0, 3'd5, 1'b0}, // R3 way 5 has count 2
        {4'd4,  2'd1, 3'd0, 8'd6, 1'b0, 3'd1, 1'b0}, // R4 ways 1,3 tie; 1 older
        {4'd6,  2'd2, 3'd3, 8'd0, 1'b0, 3'd0, 1'b0}, // R6 pin way 3
        {4'd1,  2'd1, 3'd0, 8'd9, 1'b0, 3'd7, 1'b0}, // R1 way 3 (count 3) skipped
        {4'd6,  2'd2, 3'd0, 8'd0, 1'b0, 3'd0, 1'b0}, // R6 pin way 0
        {4'd6,  2'd2, 3'd2, 8'd0, 1'b0, 3'd0, 1'b1}, // R6 third pin refused
        {4'd4,  2'd1, 3'd0, 8'd1, 1'b0, 3'd6, 1'b0}, // R4 ways 1,6 tie; 6 older
        {4'd8,  2'd0, 3'd3, 8'd0, 1'b0, 3'd0, 1'b0}, // R8 hit on pinned way 3
        {4'd6,  2'd2, 3'd3, 8'd0, 1'b0, 3'd0, 1'b0}, // R6 re-pin accepted
        {4'd7,  2'd3, 3'd0, 8'd0, 1'b0, 3'd0, 1'b0}, // R7 unpin way 0
        {4'd7,  2'd2, 3'd2, 8'd0, 1'b0, 3'd0, 1'b0}, // R7 slot freed, pin way 2
        {4'd5,  2'd1, 3'd0, 8'd0, 1'b1, 3'd0, 1'b0}, // R5 oldest unpinned way 0
        {4'd5,  2'd1, 3'd0, 8'd0, 1'b1, 3'd4, 1'b0}, // R5 way 2 oldest but pinned
        {4'd10, 2'd1, 3'd0, 8'd5, 1'b0, 3'd0, 1'b0}, // R10 counts 0 stored, tie
        {4'd8,  2'd0, 3'd5, 8'd0, 1'b0, 3'd0, 1'b0}, // R8 hit way 5
        {4'd8,  2'd1, 3'd0, 8'd0, 1'b1, 3'd1, 1'b0}  // R8 way 5 no longer oldest
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       touch_en = 1'b0;
    logic [2:0] touch_way = '0;
    logic       fill_req = 1'b0;
    logic [7:0] fill_misses = '0;
    logic       pin_req = 1'b0;
    logic       unpin_req = 1'b0;
    logic [2:0] pin_way = '0;
    logic       lru_only = 1'b0;
    logic       victim_valid;
    logic [2:0] victim_way;
    logic       pin_reject;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    missrank_victim_sel u_missrank_victim_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .touch_en     (touch_en),
        .touch_way    (touch_way),
        .fill_req     (fill_req),
        .fill_misses  (fill_misses),
        .pin_req      (pin_req),
        .unpin_req    (unpin_req),
        .pin_way      (pin_way),
        .lru_only     (lru_only),
        .victim_valid (victim_valid),
        .victim_way   (victim_way),
        .pin_reject   (pin_reject)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got {vv,way,rej}=%b expected %b", req, act, exp);
        end
    endtask

    // Drive one command at a falling edge; sample the registered result
    // at the next falling edge, after the rising edge that captured it.
    task automatic run_op(input int op, input logic [2:0] way, input logic [7:0] cnt,
                          input logic lru);
        @(negedge clk);
        lru_only    = lru;
        touch_en    = (op == OP_TOUCH);
        touch_way   = way;
        fill_req    = (op == OP_FILL);
        fill_misses = cnt;
        pin_req     = (op == OP_PIN);
        unpin_req   = (op == OP_UNPIN);
        pin_way     = way;
        @(negedge clk);
        touch_en  = 1'b0;
        fill_req  = 1'b0;
        pin_req   = 1'b0;
        unpin_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R11: quiet outputs after reset
        check("R11", {victim_valid, 3'b000, pin_reject}, 5'b0);

        for (int i = 0; i < NV; i++) begin
            logic [21:0] row;
            int          op;
            logic [4:0]  exp;
            row = VEC[i];
            op  = int'(row[17:16]);
            run_op(op, row[15:13], row[12:5], row[4]);
            if (op == OP_FILL) exp = {1'b1, row[3:1], 1'b0};
            else               exp = {1'b0, 3'b000, row[0]};
            check($sformatf("R%0d", int'(row[21:18])),
                  {victim_valid, (op == OP_FILL) ? victim_way : 3'b000, pin_reject}, exp);
        end

        // R9: the report lasts one cycle only
        @(negedge clk);
        check("R9", {victim_valid, 3'b000, pin_reject}, 5'b0);

        // R11: reset clears lines, pins and ages
        do_reset();
        run_op(OP_FILL, 3'd0, 8'd1, 1'b0);
        check("R11", {victim_valid, victim_way, pin_reject}, {1'b1, 3'd0, 1'b0});
        run_op(OP_PIN, 3'd1, 8'd0, 1'b0);
        check("R6", {victim_valid, 3'b000, pin_reject}, 5'b0);
        run_op(OP_PIN, 3'd2, 8'd0, 1'b0);
        check("R6", {victim_valid, 3'b000, pin_reject}, 5'b0);
        run_op(OP_PIN, 3'd3, 8'd0, 1'b0);
        check("R6", {victim_valid, 3'b000, pin_reject}, 5'b00001);
        // R2 with ways 1,2 pinned and invalid: next empty unpinned is way 3
        run_op(OP_FILL, 3'd0, 8'd1, 1'b0);
        check("R2", {victim_valid, victim_way, pin_reject}, {1'b1, 3'd3, 1'b0});
        // R1: invalid pinned ways 1 and 2 are skipped by the empty-way search
        run_op(OP_FILL, 3'd0, 8'd1, 1'b0);
        check("R1", {victim_valid, victim_way, pin_reject}, {1'b1, 3'd4, 1'b0});

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule